// File: doc/BRIEF.md
# UART Auto-Baud Detector

This block learns the bit rate of an asynchronous serial line at run time, so the line rate does not have to be fixed against the system clock at build time. After reset it watches the idle-high receive pin. It treats the first character that arrives as a calibration character: an uppercase 'U' (0x55), framed with one low start bit and one high stop bit and sent LSB first. That pattern changes level at every bit boundary. The width of the start bit, counted in system clock cycles, becomes the baud divisor that a separate UART receiver and transmitter use.

The detector does more than time one interval before it accepts the measurement. Each of the eight data bits must have about the same width as the start bit. The stop bit must then stay high for one full measured period. Only after that does the block raise its lock level and give a one-cycle strobe. Any character that fails a check is dropped, and the detector goes back to waiting for a start edge. Once locked, the block ignores all later line activity until a restart request re-arms it.

Top module: `autobaud_detector`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `locked` and `lockStrobe` are 0 and `baudDiv` is 0.
- R2: A valid calibration character whose start, data and stop bits each last P cycles on the pin sets `baudDiv` to exactly P. The character is start 0, then data bits 1,0,1,0,1,0,1,0 in time order (0x55 LSB first), then stop 1.
- R3: With the default two-stage synchroniser, `locked` is still 0 P+1 cycles after the stop bit begins on the pin, and it is 1 P+5 cycles after.
- R4: `lockStrobe` is high for exactly one cycle on each acquisition of lock and is never high at any other time.
- R5: Every data bit must last between P-floor(P/4) and P+floor(P/4) cycles inclusive. A character with any data bit outside that window does not lock.
- R6: The line must stay high for at least P cycles after the stop bit begins. A fall that comes earlier rejects the character. A fall after exactly P cycles does not.
- R7: A start bit shorter than MIN_PERIOD cycles (default 4) is rejected, and a start bit of exactly MIN_PERIOD is accepted.
- R8: The interval counter saturates at 2^CNT_W-1 and never wraps. A start bit of 2^CNT_W cycles or longer is discarded. The longest start bit that is accepted is 2^CNT_W-1 cycles.
- R9: After any rejected character, a following valid calibration character locks without a restart.
- R10: While locked, line activity leaves `baudDiv`, `locked` and `lockStrobe` unchanged.
- R11: A one-cycle `restart` pulse clears `locked` and sets `baudDiv` to 0 on the next cycle, and the detector then acquires again. Whenever `locked` is 0, `baudDiv` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxRaw | input | 1 | Asynchronous serial receive pin, idle high |
| restart | input | 1 | Drops the lock and re-arms acquisition |
| baudDiv | output | CNT_W | Measured bit period in clock cycles; 0 when not locked |
| locked | output | 1 | High once a calibration character has been accepted |
| lockStrobe | output | 1 | One-cycle pulse when lock is acquired |

## Verification
The hardest states to reach are the rejection paths deep inside a character. These are a data bit just outside the quarter-period window, a stop bit cut short by one cycle, and a start bit that drives the counter into saturation. None of them can happen with well-formed traffic. The bench therefore builds each character bit by bit with its own width for every bit. It places single widths exactly on the window edges and one cycle beyond them. It shortens the stop bit to P-1 and to exactly P before a short low glitch. Against a reduced counter width, it sends start bits of 2^CNT_W-1 and 2^CNT_W cycles. Random trials then push one data bit at a time across the window, and after each trial the bench expects lock or no lock.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  // strobes from the sequencer into the measurement datapath
  typedef struct packed {
    logic clrCnt;     // restart the interval counter
    logic capPeriod;  // latch the current interval as the bit period
    logic loadDiv;    // publish the latched period as the divisor
    logic clrDiv;     // zero the published divisor
  } abCtrl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic fallSeen;   // synchronised line went 1 -> 0
    logic riseSeen;   // synchronised line went 0 -> 1
    logic cntSat;     // interval counter is at its ceiling
    logic inTol;      // current interval within the quarter-period window
    logic pastTol;    // current interval above the window
    logic atPeriod;   // current interval equals the latched period
    logic tooShort;   // current interval below the minimum period
  } abStat_t;

  typedef enum logic [2:0] {
    AB_WAIT,   // idle, waiting for a start edge
    AB_MEAS,   // timing the start bit
    AB_BITS,   // checking the eight data bits
    AB_STOP,   // checking the stop bit
    AB_LOCK    // divisor published
  } abState_t;

endpackage

// File: rtl/autobaud_datapath.sv
module autobaud_datapath
  import autobaud_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int MIN_PERIOD  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxRaw,
  input  abCtrl_t          ctrl,
  output abStat_t          stat,
  output logic [CNT_W-1:0] baudDiv
);

  localparam int IV_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [IV_W-1:0]  MIN_IV  = IV_W'(MIN_PERIOD);

  // input synchroniser, reset to the idle level
  logic [SYNC_STAGES-1:0] syncQ;
  logic rxSync;
  logic rxPrev;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], rxRaw};
  end

  assign rxSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) rxPrev <= 1'b1;
    else     rxPrev <= rxSync;
  end

  // saturating interval counter
  logic [CNT_W-1:0] cntQ;
  logic [IV_W-1:0]  interval;

  always_ff @(posedge clk) begin
    if (rst || ctrl.clrCnt) cntQ <= '0;
    else if (cntQ != CNT_MAX) cntQ <= cntQ + CNT_W'(1);
  end

  assign interval = {1'b0, cntQ} + IV_W'(1);

  // latched period and tolerance window
  logic [CNT_W-1:0] periodQ;
  logic [IV_W-1:0]  periodIv;
  logic [IV_W-1:0]  quarterIv;
  logic [IV_W-1:0]  tolLo;
  logic [IV_W-1:0]  tolHi;

  always_ff @(posedge clk) begin
    if (rst)                 periodQ <= '0;
    else if (ctrl.capPeriod) periodQ <= interval[CNT_W-1:0];
  end

  assign periodIv  = {1'b0, periodQ};
  assign quarterIv = {3'b000, periodQ[CNT_W-1:2]};
  assign tolLo     = periodIv - quarterIv;
  assign tolHi     = periodIv + quarterIv;

  // published divisor
  logic [CNT_W-1:0] divQ;

  always_ff @(posedge clk) begin
    if (rst || ctrl.clrDiv) divQ <= '0;
    else if (ctrl.loadDiv)  divQ <= periodQ;
  end

  assign baudDiv = divQ;

  always_comb begin
    stat.fallSeen = rxPrev & ~rxSync;
    stat.riseSeen = ~rxPrev & rxSync;
    stat.cntSat   = (cntQ == CNT_MAX);
    stat.inTol    = (interval >= tolLo) && (interval <= tolHi);
    stat.pastTol  = (interval > tolHi);
    stat.atPeriod = (interval == periodIv);
    stat.tooShort = (interval < MIN_IV);
  end

  // R8: the counter holds at its ceiling instead of wrapping
  assert_cnt_saturates_R8: assert property (@(posedge clk) disable iff (rst)
    (cntQ == CNT_MAX && !ctrl.clrCnt) |=> (cntQ == CNT_MAX));

  // R8: a period is never captured from a saturated count
  assert_cap_unsaturated_R8: assert property (@(posedge clk) disable iff (rst)
    ctrl.capPeriod |-> !stat.cntSat);

  // R7: a captured period is never below the minimum
  assert_cap_min_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.capPeriod |=> (periodQ >= CNT_W'(MIN_PERIOD)));

endmodule

// File: rtl/autobaud_control.sv
module autobaud_control
  import autobaud_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    restart,
  input  abStat_t stat,
  output abCtrl_t ctrl,
  output logic    locked,
  output logic    lockStrobe
);

  localparam int EDGE_W = 3;
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(7); // stop-bit rise

  abState_t          state, stateNext;
  logic [EDGE_W-1:0] edgeCnt, edgeNext;
  logic              lockSet;
  logic              lockedQ, strobeQ;
  logic              anyEdge;

  assign anyEdge = stat.fallSeen | stat.riseSeen;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    edgeNext  = edgeCnt;
    lockSet   = 1'b0;
    if (restart) begin
      ctrl.clrDiv = 1'b1;
      ctrl.clrCnt = 1'b1;
      stateNext   = AB_WAIT;
    end else begin
      unique case (state)
        AB_WAIT: begin
          ctrl.clrCnt = 1'b1;
          if (stat.fallSeen) stateNext = AB_MEAS;
        end
        AB_MEAS: begin
          if (stat.cntSat) begin
            stateNext = AB_WAIT;
          end else if (stat.riseSeen) begin
            ctrl.clrCnt = 1'b1;
            if (stat.tooShort) begin
              stateNext = AB_WAIT;
            end else begin
              ctrl.capPeriod = 1'b1;
              edgeNext       = '0;
              stateNext      = AB_BITS;
            end
          end
        end
        AB_BITS: begin
          if (stat.cntSat || stat.pastTol) begin
            stateNext = AB_WAIT;
          end else if (anyEdge) begin
            ctrl.clrCnt = 1'b1;
            if (!stat.inTol)                stateNext = AB_WAIT;
            else if (edgeCnt == LAST_EDGE)  stateNext = AB_STOP;
            else                            edgeNext  = edgeCnt + EDGE_W'(1);
          end
        end
        AB_STOP: begin
          if (stat.atPeriod) begin
            ctrl.loadDiv = 1'b1;
            lockSet      = 1'b1;
            stateNext    = AB_LOCK;
          end else if (stat.fallSeen || stat.cntSat) begin
            stateNext = AB_WAIT;
          end
        end
        AB_LOCK: ctrl.clrCnt = 1'b1;
        default: stateNext = AB_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= AB_WAIT;
      edgeCnt <= '0;
      lockedQ <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      state   <= stateNext;
      edgeCnt <= edgeNext;
      strobeQ <= lockSet;
      if (restart)      lockedQ <= 1'b0;
      else if (lockSet) lockedQ <= 1'b1;
    end
  end

  assign locked     = lockedQ;
  assign lockStrobe = strobeQ;

  // R6: lock is only ever entered from the stop-bit check
  assert_lock_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(lockedQ) |-> ($past(state) == AB_STOP));

  // R11: restart drops the lock on the next cycle
  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (rst)
    restart |=> !lockedQ);

  // R10: lock persists until restart
  assert_lock_held_R10: assert property (@(posedge clk) disable iff (rst)
    (lockedQ && !restart) |=> lockedQ);

  // R4: strobe lasts one cycle
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    strobeQ |=> !strobeQ);

endmodule

// File: rtl/autobaud_detector.sv
module autobaud_detector
  import autobaud_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int MIN_PERIOD  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxRaw,
  input  logic             restart,
  output logic [CNT_W-1:0] baudDiv,
  output logic             locked,
  output logic             lockStrobe
);

  abCtrl_t ctrlBus;
  abStat_t statBus;

  autobaud_datapath #(
    .CNT_W      (CNT_W),
    .MIN_PERIOD (MIN_PERIOD),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk    (clk),
    .rst    (rst),
    .rxRaw  (rxRaw),
    .ctrl   (ctrlBus),
    .stat   (statBus),
    .baudDiv(baudDiv)
  );

  autobaud_control u_control (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .stat      (statBus),
    .ctrl      (ctrlBus),
    .locked    (locked),
    .lockStrobe(lockStrobe)
  );

  // R11: divisor reads zero whenever unlocked
  assert_div_zero_unlocked_R11: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (baudDiv == '0));

  // R7: a locked divisor respects the minimum period
  assert_div_floor_R7: assert property (@(posedge clk) disable iff (rst)
    locked |-> (baudDiv >= CNT_W'(MIN_PERIOD)));

  // R4: strobe only marks the first locked cycle
  assert_strobe_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    lockStrobe |-> (locked && !$past(locked)));

endmodule

// File: tb/tb_autobaud_detector.sv
module tb_autobaud_detector;

  localparam int CW   = 11;
  localparam int MINP = 4;
  localparam int PMAX = (1 << CW) - 1;
  localparam logic [7:0] CAL = 8'h55;

  logic clk = 1'b0;
  logic rst, rxRaw, restart;
  logic [CW-1:0] baudDiv;
  logic locked, lockStrobe;

  always #2.5 clk = ~clk;

  autobaud_detector #(.CNT_W(CW), .MIN_PERIOD(MINP), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .rxRaw(rxRaw), .restart(restart),
    .baudDiv(baudDiv), .locked(locked), .lockStrobe(lockStrobe)
  );

  int nChecks = 0;
  int nFail = 0;
  int strobeCnt = 0;
  int expStrobe = 0;
  bit doubleStrobe = 0;
  bit prevStrobe = 0;
  int bitW [8];

  always @(negedge clk) begin
    if (lockStrobe) strobeCnt++;
    if (lockStrobe && prevStrobe) doubleStrobe = 1'b1;
    prevStrobe = lockStrobe;
  end

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tolLo(int p); return p - p / 4; endfunction
  function automatic int tolHi(int p); return p + p / 4; endfunction

  function automatic bit frameOk(int p, int stopW);
    bit ok = (p >= MINP) && (p <= PMAX) && (stopW >= p);
    for (int k = 0; k < 8; k++)
      if (bitW[k] < tolLo(p) || bitW[k] > tolHi(p)) ok = 1'b0;
    return ok;
  endfunction

  task automatic drive(bit v, int n);
    rxRaw = v;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic setUniform(int p);
    for (int k = 0; k < 8; k++) bitW[k] = p;
  endtask

  task automatic sendChar(int p, int stopW, bit glitch, bit timeCheck);
    drive(1'b0, p);
    for (int k = 0; k < 8; k++) drive(CAL[k], bitW[k]);
    rxRaw = 1'b1;
    for (int i = 1; i <= stopW; i++) begin
      @(posedge clk); #1;
      if (timeCheck && i == p + 1) chk("R3", "locked before stop verified", int'(locked), 0);
      if (timeCheck && i == p + 5) chk("R3", "locked after stop verified", int'(locked), 1);
    end
    if (glitch) drive(1'b0, 2);
    drive(1'b1, 4 * p + 40);
  endtask

  task automatic runChar(string req, int p, int stopW, bit glitch);
    bit exp = frameOk(p, stopW);
    sendChar(p, stopW, glitch, exp && (stopW >= p + 5));
    chk(req, "locked", int'(locked), int'(exp));
    chk(req, "baudDiv", int'(baudDiv), exp ? p : 0);
    if (exp) expStrobe++;
  endtask

  task automatic doRestart();
    restart = 1'b1;
    @(posedge clk); #1;
    restart = 1'b0;
    chk("R11", "locked after restart", int'(locked), 0);
    chk("R11", "baudDiv after restart", int'(baudDiv), 0);
  endtask

  initial begin
    int unsigned seed = $urandom(32'd4242);
    rst = 1'b1; rxRaw = 1'b1; restart = 1'b0;
    repeat (5) begin @(posedge clk); #1; end
    chk("R1", "locked in reset", int'(locked), 0);
    chk("R1", "strobe in reset", int'(lockStrobe), 0);
    chk("R1", "baudDiv in reset", int'(baudDiv), 0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "locked after reset", int'(locked), 0);
    drive(1'b1, 10);

    // R2, R3: nominal character
    setUniform(16);
    runChar("R2", 16, 30, 1'b0);

    // R10: later traffic ignored while locked
    setUniform(9);
    sendChar(9, 30, 1'b0, 1'b0);
    chk("R10", "baudDiv held", int'(baudDiv), 16);
    chk("R10", "locked held", int'(locked), 1);
    chk("R10", "no extra strobe", strobeCnt, expStrobe);
    doRestart();

    // R7: minimum period boundary
    setUniform(3);
    runChar("R7", 3, 20, 1'b0);
    setUniform(4);
    runChar("R7", 4, 20, 1'b0);
    doRestart();

    // R5: data bit window edges for P=20 (15..25)
    setUniform(20); bitW[3] = 14;
    runChar("R5", 20, 40, 1'b0);
    setUniform(20); bitW[3] = 15;
    runChar("R5", 20, 40, 1'b0);
    doRestart();
    setUniform(20); bitW[6] = 25;
    runChar("R5", 20, 40, 1'b0);
    doRestart();
    setUniform(20); bitW[0] = 26;
    runChar("R5", 20, 40, 1'b0);

    // R6: stop bit length
    setUniform(12);
    runChar("R6", 12, 11, 1'b1);
    setUniform(12);
    runChar("R6", 12, 12, 1'b1);
    doRestart();

    // R8: start held low past the counter ceiling
    drive(1'b0, PMAX + 60);
    drive(1'b1, 200);
    chk("R8", "locked after overlong low", int'(locked), 0);
    chk("R8", "baudDiv after overlong low", int'(baudDiv), 0);

    // R9: valid character after a rejection
    setUniform(10);
    runChar("R9", 10, 25, 1'b0);
    doRestart();

    // R8: largest accepted period and one beyond
    setUniform(PMAX);
    runChar("R8", PMAX, PMAX + 10, 1'b0);
    doRestart();
    setUniform(PMAX + 1);
    runChar("R8", PMAX + 1, PMAX + 10, 1'b0);

    // R5/R2: random single-bit perturbations
    for (int t = 0; t < 16; t++) begin
      int p = MINP + int'($urandom % 150);
      int idx = int'($urandom % 8);
      int delta = int'($urandom % (p + 1)) - p / 2;
      setUniform(p);
      bitW[idx] = (p + delta < 1) ? 1 : p + delta;
      runChar("R5", p, p + 8, 1'b0);
      if (locked) doRestart();
    end

    chk("R4", "strobe count", strobeCnt, expStrobe);
    chk("R4", "strobe width", int'(doubleStrobe), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule